// File: doc/BRIEF.md
# Subword Register Reservation Cascade

This block keeps track of which parts of each 64-bit register are held by operations in flight. An operation can work on the whole register or on a 32-bit, 16-bit or 8-bit lane of it. Each register holds one reservation bit per byte. A request names a register, a width code and a lane number. The block turns the request into a byte mask and reports in the same cycle whether that mask meets any byte that is already held. Because a wide request covers many bytes and a narrow one covers few, the per-byte check gives the cascading rule. A whole-register hold blocks every narrower lane inside it. A single held byte blocks every wider portion that contains it. Lanes that share no byte stay free.

An issue stage puts the request on the query inputs and reads `conflict_o` and `bad_o`. If the request is clean, the issue stage pulses `acc_i` for one cycle to record the hold. When the operation completes, the release inputs clear the bytes of its own mask. The release port is separate from the query port, so a completion and a new issue can happen in the same cycle. An accept that arrives while the request conflicts, or while the request is malformed, changes nothing and raises `err_o` for one cycle.

Top module: `subres_cascade`

## Requirements
- R1: After reset no byte of any register is held, so every well-formed query reports `conflict_o` low and `err_o` is low.
- R2: The width code selects the byte mask, with bit n standing for byte n (bits 8n+7..8n). Code 0 is 8 bits and gives mask 1<<lane, lane 0..7. Code 1 is 16 bits and gives 0x03<<(2*lane), lane 0..3. Code 2 is 32 bits and gives 0x0F<<(4*lane), lane 0..1. Code 3 is 64 bits and gives 0xFF, lane 0. `conflict_o` is high exactly when this mask shares a bit with the bytes held for the queried register.
- R3: While a register is held at width 64, every 32-, 16- and 8-bit lane of that register reports a conflict.
- R4: While one byte is held, the 16-, 32- and 64-bit portions that contain it report a conflict. The other bytes, and the 16- and 32-bit lanes that do not contain it, report none.
- R5: While a 32-bit lane is held, the 16- and 8-bit lanes inside it report a conflict. The other 32-bit half and its sub-lanes report none.
- R6: A lane number at or above the lane count for its width sets `bad_o` high and `conflict_o` low. An accept of such a request holds nothing and raises `err_o`.
- R7: An accept while `conflict_o` is high is ignored. The held bytes are unchanged and `err_o` is high for exactly the next cycle. A clean accept leaves `err_o` low.
- R8: A release clears only the bytes of its own mask in its own register. Other held bytes of that register stay held.
- R9: When an accept and a release come in the same cycle, the query is judged against the holds as they stood before that cycle. Both take effect at the next edge, and on a shared byte the accept wins.
- R10: Holds on one register never make a query on another register conflict.
- R11: A clean accept takes effect at the next clock edge. From that cycle on, the same query reports a conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears every hold |
| q_reg_i | input | $clog2(NREG) | Register index of the query |
| q_width_i | input | 2 | Width code of the query (0=8, 1=16, 2=32, 3=64 bits) |
| q_lane_i | input | 3 | Lane number of the query within its width |
| acc_i | input | 1 | One-cycle pulse: record the query as a hold |
| rel_i | input | 1 | One-cycle pulse: clear the release mask |
| rel_reg_i | input | $clog2(NREG) | Register index of the release |
| rel_width_i | input | 2 | Width code of the release |
| rel_lane_i | input | 3 | Lane number of the release |
| conflict_o | output | 1 | Query mask meets held bytes (combinational) |
| bad_o | output | 1 | Query lane or register index out of range (combinational) |
| err_o | output | 1 | High one cycle after a rejected accept |

## Verification
Accept and release can land in the same cycle, either on the same register or on different ones. The bench provokes this by driving both pulses at one falling edge. In one case the release frees bytes of one register while an accept claims bytes of another. In another case both name the same 16-bit lane of one register. The bench judges the result by the conflict answer in that cycle, which must still reflect the old holds. It then queries each affected lane in the following cycles: released bytes must read free, and claimed bytes, including those the release also named, must read held.

// File: rtl/subres_pkg.sv
`timescale 1ns/1ps
package subres_pkg;

    localparam int unsigned BYTES_PER_REG = 8;
    localparam int unsigned LANE_W        = $clog2(BYTES_PER_REG);
    localparam int unsigned NUM_WIDTHS    = $clog2(BYTES_PER_REG) + 1;

    typedef enum logic [1:0] {
        SW_B8  = 2'd0,
        SW_B16 = 2'd1,
        SW_B32 = 2'd2,
        SW_B64 = 2'd3
    } sub_width_e;

    typedef logic [BYTES_PER_REG-1:0] byte_mask_t;

endpackage

// File: rtl/subres_mask_gen.sv
`timescale 1ns/1ps
module subres_mask_gen
    import subres_pkg::*;
(
    input  sub_width_e          width_i,
    input  logic [LANE_W-1:0]   lane_i,
    output byte_mask_t          mask_o,
    output logic                misalign_o
);

    byte_mask_t             cand_mask [NUM_WIDTHS];
    logic [NUM_WIDTHS-1:0]  cand_ok;

    // One candidate mask per width; the width code selects one.
    for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
        localparam int unsigned SPAN  = 1 << k;
        localparam int unsigned LANES = BYTES_PER_REG / SPAN;
        localparam byte_mask_t  UNIT  = byte_mask_t'((1 << SPAN) - 1);

        assign cand_ok[k]   = (32'(lane_i) < LANES);
        assign cand_mask[k] = UNIT << (32'(lane_i) * SPAN);
    end

    always_comb begin
        mask_o     = '0;
        misalign_o = 1'b1;
        unique case (width_i)
            SW_B8: begin
                misalign_o = !cand_ok[0];
                mask_o     = cand_ok[0] ? cand_mask[0] : '0;
            end
            SW_B16: begin
                misalign_o = !cand_ok[1];
                mask_o     = cand_ok[1] ? cand_mask[1] : '0;
            end
            SW_B32: begin
                misalign_o = !cand_ok[2];
                mask_o     = cand_ok[2] ? cand_mask[2] : '0;
            end
            SW_B64: begin
                misalign_o = !cand_ok[3];
                mask_o     = cand_ok[3] ? cand_mask[3] : '0;
            end
            default: begin
                misalign_o = 1'b1;
                mask_o     = '0;
            end
        endcase
    end

endmodule

// File: rtl/subres_table.sv
`timescale 1ns/1ps
module subres_table
    import subres_pkg::*;
#(
    parameter  int unsigned NREG = 16,
    localparam int unsigned RW   = $clog2(NREG)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_en_i,
    input  logic [RW-1:0] set_idx_i,
    input  byte_mask_t  set_mask_i,
    input  logic        clr_en_i,
    input  logic [RW-1:0] clr_idx_i,
    input  byte_mask_t  clr_mask_i,
    input  logic [RW-1:0] rd_idx_i,
    output byte_mask_t  rd_mask_o
);

    byte_mask_t held_q [NREG];

    // One byte-hold register per architectural register.
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic       hit_set;
        logic       hit_clr;
        byte_mask_t set_bits;
        byte_mask_t clr_bits;

        assign hit_set  = set_en_i && (32'(set_idx_i) == r);
        assign hit_clr  = clr_en_i && (32'(clr_idx_i) == r);
        assign set_bits = hit_set ? set_mask_i : '0;
        assign clr_bits = hit_clr ? clr_mask_i : '0;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held_q[r] <= '0;
            end else if (hit_set || hit_clr) begin
                held_q[r] <= (held_q[r] & ~clr_bits) | set_bits;
            end
        end
    end

    always_comb begin
        rd_mask_o = '0;
        for (int r = 0; r < NREG; r++) begin
            if (32'(rd_idx_i) == r) begin
                rd_mask_o = held_q[r];
            end
        end
    end

endmodule

// File: rtl/subres_cascade.sv
`timescale 1ns/1ps
module subres_cascade
    import subres_pkg::*;
#(
    parameter  int unsigned NREG = 16,
    localparam int unsigned RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] q_reg_i,
    input  logic [1:0]    q_width_i,
    input  logic [2:0]    q_lane_i,
    input  logic          acc_i,
    input  logic          rel_i,
    input  logic [RW-1:0] rel_reg_i,
    input  logic [1:0]    rel_width_i,
    input  logic [2:0]    rel_lane_i,
    output logic          conflict_o,
    output logic          bad_o,
    output logic          err_o
);

    localparam logic [RW:0] NREG_W = (RW+1)'(NREG);

    byte_mask_t q_mask;
    byte_mask_t rel_mask;
    byte_mask_t held_mask;
    logic       q_misalign;
    logic       rel_misalign;
    logic       q_idx_ok;
    logic       rel_idx_ok;
    logic       q_bad;
    logic       q_conflict;
    logic       acc_take;
    logic       rel_take;
    logic       err_q;

    subres_mask_gen u_qmask (
        .width_i    (sub_width_e'(q_width_i)),
        .lane_i     (q_lane_i),
        .mask_o     (q_mask),
        .misalign_o (q_misalign)
    );

    subres_mask_gen u_rmask (
        .width_i    (sub_width_e'(rel_width_i)),
        .lane_i     (rel_lane_i),
        .mask_o     (rel_mask),
        .misalign_o (rel_misalign)
    );

    assign q_idx_ok   = ({1'b0, q_reg_i}   < NREG_W);
    assign rel_idx_ok = ({1'b0, rel_reg_i} < NREG_W);

    assign q_bad      = q_misalign || !q_idx_ok;
    assign q_conflict = !q_bad && |(q_mask & held_mask);

    assign acc_take   = acc_i && !q_bad && !q_conflict;
    assign rel_take   = rel_i && !rel_misalign && rel_idx_ok;

    subres_table #(.NREG(NREG)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en_i   (acc_take),
        .set_idx_i  (q_reg_i),
        .set_mask_i (q_mask),
        .clr_en_i   (rel_take),
        .clr_idx_i  (rel_reg_i),
        .clr_mask_i (rel_mask),
        .rd_idx_i   (q_reg_i),
        .rd_mask_o  (held_mask)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= acc_i && (q_bad || q_conflict);
        end
    end

    assign conflict_o = q_conflict;
    assign bad_o      = q_bad;
    assign err_o      = err_q;

endmodule

// File: rtl/subres_cascade_chk.sv
`timescale 1ns/1ps
module subres_cascade_chk #(
    parameter  int unsigned NREG = 16,
    localparam int unsigned RW   = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [RW-1:0] q_reg_i,
    input logic [1:0]    q_width_i,
    input logic [2:0]    q_lane_i,
    input logic          acc_i,
    input logic          rel_i,
    input logic [RW-1:0] rel_reg_i,
    input logic [1:0]    rel_width_i,
    input logic [2:0]    rel_lane_i,
    input logic          conflict_o,
    input logic          bad_o,
    input logic          err_o
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !past_ok |-> (!conflict_o && !err_o));

    p_reject_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && (conflict_o || bad_o)) |=> err_o);

    p_clean_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_i && (conflict_o || bad_o)) |=> !err_o);

    p_bad_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_o |-> !conflict_o);

    p_wide_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_width_i == 2'd3 && q_lane_i != 3'd0) |-> bad_o);

    p_hold_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(acc_i && !conflict_o && !bad_o && !rel_i)
         && $stable(q_reg_i) && $stable(q_width_i) && $stable(q_lane_i))
        |-> conflict_o);

    // Release inputs carry no property of their own here; keep them observed.
    p_release_known_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rel_i |-> !$isunknown({rel_reg_i, rel_width_i, rel_lane_i}));

endmodule

bind subres_cascade subres_cascade_chk #(.NREG(NREG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .q_reg_i     (q_reg_i),
    .q_width_i   (q_width_i),
    .q_lane_i    (q_lane_i),
    .acc_i       (acc_i),
    .rel_i       (rel_i),
    .rel_reg_i   (rel_reg_i),
    .rel_width_i (rel_width_i),
    .rel_lane_i  (rel_lane_i),
    .conflict_o  (conflict_o),
    .bad_o       (bad_o),
    .err_o       (err_o)
);

// File: tb/subres_cascade_tb.sv
`timescale 1ns/1ps
module subres_cascade_tb;

    localparam int NREG = 16;
    localparam int RW   = $clog2(NREG);

    typedef struct packed {
        logic          acc;
        logic          rel;
        logic [RW-1:0] qreg;
        logic [1:0]    qw;
        logic [2:0]    ql;
        logic [RW-1:0] rreg;
        logic [1:0]    rw;
        logic [2:0]    rl;
        logic          conf;
        logic          bad;
        logic          errn;
        logic [3:0]    req;
    } vec_t;

    function automatic vec_t mk(int acc, int rel, int qreg, int qw, int ql,
                                int rreg, int rw, int rl,
                                int conf, int bad, int errn, int req);
        vec_t v;
        v.acc  = 1'(acc);   v.rel = 1'(rel);
        v.qreg = RW'(qreg); v.qw  = 2'(qw);  v.ql = 3'(ql);
        v.rreg = RW'(rreg); v.rw  = 2'(rw);  v.rl = 3'(rl);
        v.conf = 1'(conf);  v.bad = 1'(bad); v.errn = 1'(errn);
        v.req  = 4'(req);
        return v;
    endfunction

    localparam int NV = 33;
    //                 acc rel qreg qw ql rreg rw rl conf bad errn req
    localparam vec_t VECS [NV] = '{
        mk(0,0, 0,3,0, 0,0,0, 0,0,0, 1),  // R1 fresh
        mk(1,0, 1,3,0, 0,0,0, 0,0,0, 3),  // R3 hold r1 whole
        mk(0,0, 1,0,5, 0,0,0, 1,0,0, 3),  // R3 byte 5
        mk(0,0, 1,1,3, 0,0,0, 1,0,0, 3),  // R3 16-bit lane 3
        mk(0,0, 1,2,1, 0,0,0, 1,0,0, 3),  // R3 32-bit lane 1
        mk(0,0, 2,3,0, 0,0,0, 0,0,0,10),  // R10 other register free
        mk(1,0, 1,0,2, 0,0,0, 1,0,1, 7),  // R7 rejected accept
        mk(0,1, 1,0,2, 1,3,0, 1,0,0, 9),  // R9 release not visible yet
        mk(0,0, 1,0,2, 0,0,0, 0,0,0, 8),  // R8 released
        mk(1,0, 3,0,0, 0,0,0, 0,0,0, 4),  // R4 hold r3 byte 0
        mk(0,0, 3,1,0, 0,0,0, 1,0,0, 4),  // R4
        mk(0,0, 3,2,0, 0,0,0, 1,0,0, 4),  // R4
        mk(0,0, 3,3,0, 0,0,0, 1,0,0, 4),  // R4
        mk(0,0, 3,0,1, 0,0,0, 0,0,0, 4),  // R4 neighbour byte free
        mk(0,0, 3,1,1, 0,0,0, 0,0,0, 4),  // R4 other 16-bit lane free
        mk(0,0, 3,2,1, 0,0,0, 0,0,0, 4),  // R4 other 32-bit half free
        mk(1,0, 4,2,1, 0,0,0, 0,0,0, 5),  // R5 hold r4 bytes 4..7
        mk(0,0, 4,1,2, 0,0,0, 1,0,0, 5),  // R5
        mk(0,0, 4,0,7, 0,0,0, 1,0,0, 5),  // R5
        mk(0,0, 4,1,1, 0,0,0, 0,0,0, 5),  // R5
        mk(0,0, 4,2,0, 0,0,0, 0,0,0, 5),  // R5
        mk(0,0, 4,2,2, 0,0,0, 0,1,0, 6),  // R6 32-bit lane 2
        mk(1,0, 5,3,1, 0,0,0, 0,1,1, 6),  // R6 bad accept
        mk(0,0, 5,3,0, 0,0,0, 0,0,0, 6),  // R6 nothing held
        mk(1,1, 5,1,2, 4,0,5, 0,0,0, 9),  // R9 accept r5 + release r4 byte 5
        mk(0,0, 4,0,5, 0,0,0, 0,0,0, 8),  // R8 byte 5 freed
        mk(0,0, 4,0,4, 0,0,0, 1,0,0, 8),  // R8 byte 4 still held
        mk(0,0, 5,0,4, 0,0,0, 1,0,0, 9),  // R9 accept landed
        mk(1,1, 6,1,3, 6,1,3, 0,0,0, 9),  // R9 same lane both
        mk(0,0, 6,0,6, 0,0,0, 1,0,0, 9),  // R9 accept wins
        mk(1,0, 7,0,7, 0,0,0, 0,0,0, 2),  // R2 byte 7
        mk(1,0, 7,0,6, 0,0,0, 0,0,0, 2),  // R2 byte 6 free
        mk(0,0, 7,1,3, 0,0,0, 1,0,0, 2)   // R2 16-bit lane 3 = bytes 6,7
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] q_reg_i = '0;
    logic [1:0]    q_width_i = '0;
    logic [2:0]    q_lane_i = '0;
    logic          acc_i = 1'b0;
    logic          rel_i = 1'b0;
    logic [RW-1:0] rel_reg_i = '0;
    logic [1:0]    rel_width_i = '0;
    logic [2:0]    rel_lane_i = '0;
    logic          conflict_o;
    logic          bad_o;
    logic          err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    subres_cascade #(.NREG(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .q_reg_i(q_reg_i), .q_width_i(q_width_i), .q_lane_i(q_lane_i),
        .acc_i(acc_i), .rel_i(rel_i),
        .rel_reg_i(rel_reg_i), .rel_width_i(rel_width_i), .rel_lane_i(rel_lane_i),
        .conflict_o(conflict_o), .bad_o(bad_o), .err_o(err_o)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic drive(logic acc, logic rel, int qreg, int qw, int ql,
                         int rreg, int rw, int rl);
        acc_i = acc; rel_i = rel;
        q_reg_i = RW'(qreg); q_width_i = 2'(qw); q_lane_i = 3'(ql);
        rel_reg_i = RW'(rreg); rel_width_i = 2'(rw); rel_lane_i = 3'(rl);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic prev_err;
        prev_err = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1 reset err", err_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset conflict", conflict_o, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].acc, VECS[i].rel, int'(VECS[i].qreg), int'(VECS[i].qw),
                  int'(VECS[i].ql), int'(VECS[i].rreg), int'(VECS[i].rw),
                  int'(VECS[i].rl));
            #1;
            chk($sformatf("R%0d conflict vec %0d", VECS[i].req, i), conflict_o, VECS[i].conf);
            chk($sformatf("R%0d bad vec %0d", VECS[i].req, i), bad_o, VECS[i].bad);
            chk($sformatf("R7 err before vec %0d", i), err_o, prev_err);
            prev_err = VECS[i].errn;
        end
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        #1;
        chk("R7 err after last vec", err_o, prev_err);

        // R11: clean accept visible in the next cycle, with err low
        @(negedge clk);
        drive(1, 0, 9, 3, 0, 0, 0, 0);
        #1 chk("R11 before accept", conflict_o, 1'b0);
        @(negedge clk);
        drive(0, 0, 9, 3, 0, 0, 0, 0);
        #1;
        chk("R11 after accept", conflict_o, 1'b1);
        chk("R7 clean accept no err", err_o, 1'b0);

        // R1: reset in mid-run clears every hold
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 r9 cleared", conflict_o, 1'b0);
        drive(0, 0, 4, 0, 4, 0, 0, 0);
        #1 chk("R1 r4 cleared", conflict_o, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule